// File: doc/BRIEF.md
# Oldest-Ready Entry Scheduler

This block holds a small pool of pending operations and selects one of them in each cycle that a shared resource can accept work. The selection always goes to the ready entry that arrived first. Arrival order is kept in a pairwise age matrix, not in a fixed priority or a rotating pointer. As a result, an operation that becomes ready late still beats every younger ready operation, whatever slot it sits in.

New operations are written into the lowest-numbered free slot. A slot's ready flag is raised from outside through a per-slot strobe. When the resource-available input is high and at least one valid entry is ready, the block drives a one-hot grant in the same cycle. At the next clock edge the granted entry is removed and its slot becomes free. When all slots are occupied, an allocation request is dropped.

Top module: `oldest_ready_sched`

## Requirements
- R1: The pool has ten slots by default. An allocation request takes the lowest-numbered free slot at the next clock edge. A request made while all ten slots are valid is dropped and changes no slot.
- R2: `grant_o` is all zero in every cycle where `res_avail_i` is 0.
- R3: `grant_o` has at most one bit set in any cycle.
- R4: When `res_avail_i` is 1, `grant_o` has the bit set for the valid, ready entry that was allocated before every other valid, ready entry. Bit k of `grant_o` stands for slot k.
- R5: A granted entry is removed at the clock edge that ends its grant cycle. It is not granted again unless it is allocated anew.
- R6: Bit k of `ready_set_i` marks slot k ready from the next edge, but only if slot k is valid in that cycle. A strobe to a free slot has no effect, so an entry later allocated there stays not ready.
- R7: Whenever `res_avail_i` is 1 and any valid entry is ready, exactly one grant is issued.
- R8: With `rst_n` low at a clock edge, all slots become free and not ready and all age relations are cleared. After reset, no grant appears until an entry is allocated and marked ready.
- R9: An entry allocated into a slot freed by an earlier grant is younger than every entry that was already valid at its allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_i | input | 1 | Request to place a new operation in a free slot |
| ready_set_i | input | NUM_ENTRIES | Per-slot strobe that marks a valid entry ready |
| res_avail_i | input | 1 | Shared resource can accept one operation this cycle |
| grant_o | output | NUM_ENTRIES | One-hot grant of the oldest ready entry, or zero |

## Verification
The hardest case to reach is an age order that differs from slot order. Producing it requires freeing slots in the middle of the pool while older entries are still waiting, then refilling those holes so that low-numbered slots hold the youngest work. A directed sequence builds exactly this pattern and checks the resulting grant order. A long random phase then mixes allocation, sparse ready strobes and intermittent resource availability, so that holes open and refill many times. A further directed step strobes ready on free slots and then allocates into them, to show the strobe was lost.

// File: rtl/osched_pkg.sv
// Package: shared constants and helpers for the oldest-ready scheduler.
// Assumes: nothing beyond a standard SystemVerilog elaborator.
package osched_pkg;

    // Default number of entries in the scheduling pool.
    parameter int unsigned OSCHED_DEFAULT_ENTRIES = 10;

    // Number of bits needed to hold a count of n items.
    function automatic int unsigned osched_count_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/osched_slot_alloc.sv
// Module: osched_slot_alloc
// Finds the lowest-numbered free slot and returns it one-hot when a request
// is present. Returns zero when the pool is full or no request is made.
// Assumes: slot_valid is the registered occupancy from the entry state.
module osched_slot_alloc #(
    parameter int unsigned N = 10
) (
    input  logic         alloc_req,
    input  logic [N-1:0] slot_valid,
    output logic [N-1:0] alloc_onehot
);

    logic [N-1:0] free_mask;
    logic [N-1:0] lowest_free;

    // Isolate the lowest set bit of the free mask and gate it with the request.
    always_comb begin
        free_mask    = ~slot_valid;
        lowest_free  = free_mask & (~free_mask + {{(N-1){1'b0}}, 1'b1});
        alloc_onehot = alloc_req ? lowest_free : '0;
    end

endmodule

// File: rtl/osched_entry_state.sv
// Module: osched_entry_state
// Holds the valid and ready flag of every slot. A slot becomes valid on
// allocation and stops being valid when it is granted. The ready flag can
// only be raised while the slot is valid.
// Assumes: alloc_onehot only targets slots that are not valid, and grant only
// targets slots that are valid and ready.
module osched_entry_state #(
    parameter int unsigned N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] alloc_onehot,
    input  logic [N-1:0] ready_set,
    input  logic [N-1:0] grant,
    output logic [N-1:0] slot_valid,
    output logic [N-1:0] slot_ready
);

    logic [N-1:0] valid_next;
    logic [N-1:0] ready_next;

    // Work out the occupancy and readiness for the next cycle.
    always_comb begin
        valid_next = (slot_valid & ~grant) | alloc_onehot;
        ready_next = (slot_ready | (ready_set & slot_valid)) & slot_valid & ~grant;
    end

    // Register the flags, clearing them all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_valid <= '0;
            slot_ready <= '0;
        end else begin
            slot_valid <= valid_next;
            slot_ready <= ready_next;
        end
    end

endmodule

// File: rtl/osched_age_matrix.sv
// Module: osched_age_matrix
// Pairwise age matrix with the oldest-ready pick.
// Bit j of row i is set when slot j holds an entry that arrived before slot i.
// When a slot is allocated, its row is loaded with the set of entries that
// remain valid. When a slot is granted, its column is cleared everywhere.
// Assumes: one allocation per cycle at most, and a set row bit only ever
// points at a valid slot (kept true by the column clear).
module osched_age_matrix #(
    parameter int unsigned N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         res_avail,
    input  logic [N-1:0] slot_valid,
    input  logic [N-1:0] slot_ready,
    input  logic [N-1:0] alloc_onehot,
    output logic [N-1:0] grant
);

    logic [N-1:0] older_q [N];
    logic [N-1:0] candidates;

    // Entries that may compete this cycle.
    always_comb begin
        candidates = slot_valid & slot_ready;
    end

    for (genvar gi = 0; gi < N; gi++) begin : g_row
        logic blocked;

        // Row gi is blocked by any older entry that is also a candidate.
        always_comb begin
            blocked   = |(older_q[gi] & candidates);
            grant[gi] = res_avail & candidates[gi] & ~blocked;
        end

        // Load the row on allocation, else drop the columns being granted.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                older_q[gi] <= '0;
            end else if (alloc_onehot[gi]) begin
                older_q[gi] <= slot_valid & ~grant;
            end else begin
                older_q[gi] <= older_q[gi] & ~grant;
            end
        end
    end

endmodule

// File: rtl/oldest_ready_sched.sv
// Module: oldest_ready_sched (top)
// Pool of pending operations. Each cycle the resource is available, it grants
// the oldest entry that is ready. It joins the free-slot finder, the per-slot
// flags and the age matrix.
// Assumes: inputs are synchronous to clk. grant_o is combinational from the
// registered state and res_avail_i.
module oldest_ready_sched #(
    parameter int unsigned NUM_ENTRIES = osched_pkg::OSCHED_DEFAULT_ENTRIES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_i,
    input  logic [NUM_ENTRIES-1:0] ready_set_i,
    input  logic                   res_avail_i,
    output logic [NUM_ENTRIES-1:0] grant_o
);

    localparam int unsigned N = NUM_ENTRIES;

    logic [N-1:0] slot_valid;
    logic [N-1:0] slot_ready;
    logic [N-1:0] alloc_onehot;
    logic [N-1:0] pick;

    osched_slot_alloc #(.N(N)) u_alloc (
        .alloc_req    (alloc_i),
        .slot_valid   (slot_valid),
        .alloc_onehot (alloc_onehot)
    );

    osched_entry_state #(.N(N)) u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_onehot (alloc_onehot),
        .ready_set    (ready_set_i),
        .grant        (pick),
        .slot_valid   (slot_valid),
        .slot_ready   (slot_ready)
    );

    osched_age_matrix #(.N(N)) u_age (
        .clk          (clk),
        .rst_n        (rst_n),
        .res_avail    (res_avail_i),
        .slot_valid   (slot_valid),
        .slot_ready   (slot_ready),
        .alloc_onehot (alloc_onehot),
        .grant        (pick)
    );

    // Drive the grant port from the age-matrix pick.
    always_comb begin
        grant_o = pick;
    end

endmodule

// File: rtl/osched_checker.sv
// Module: osched_checker
// Property checks for oldest_ready_sched, attached with bind below.
// Assumes: reset is held low from time zero for at least one edge.
module osched_checker #(
    parameter int unsigned N = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         res_avail,
    input logic         alloc_req,
    input logic [N-1:0] grant,
    input logic [N-1:0] valid,
    input logic [N-1:0] ready
);

    // R2: no grant while the resource is busy.
    assert_no_grant_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_avail |-> (grant == '0));

    // R3: grant never has more than one bit set.
    assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R4: a granted slot is one that is valid and ready.
    assert_grant_is_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~(valid & ready)) == '0);

    // R5: the granted slot is free at the next cycle.
    assert_grant_removes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |=> ((valid & $past(grant)) == '0));

    // R7: something is granted when work is ready and the resource is free.
    assert_grant_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_avail && ((valid & ready) != '0)) |-> (grant != '0));

    // R1: a request into a full pool with no grant leaves it full.
    assert_full_refuse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && (&valid) && (grant == '0)) |=> (&valid));

    // R8: reset empties the pool.
    assert_reset_clears_R8: assert property (@(posedge clk)
        !rst_n |=> ((valid == '0) && (ready == '0)));

endmodule

bind oldest_ready_sched osched_checker #(.N(NUM_ENTRIES)) u_osched_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_avail (res_avail_i),
    .alloc_req (alloc_i),
    .grant     (grant_o),
    .valid     (slot_valid),
    .ready     (slot_ready)
);

// File: tb/oldest_ready_sched_bench.sv
module oldest_ready_sched_bench;

    localparam int N        = 10;
    localparam int CLK_PER  = 10;
    localparam int MAX_CYC  = 200000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         alloc_i = 1'b0;
    logic [N-1:0] ready_set_i = '0;
    logic         res_avail_i = 1'b0;
    logic [N-1:0] grant_o;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    // Reference model state
    bit          m_valid [N];
    bit          m_ready [N];
    int unsigned m_age   [N];
    int unsigned m_stamp = 0;

    always #(CLK_PER/2) clk = ~clk;

    oldest_ready_sched #(.NUM_ENTRIES(N)) u_oldest_ready_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_i     (alloc_i),
        .ready_set_i (ready_set_i),
        .res_avail_i (res_avail_i),
        .grant_o     (grant_o)
    );

    function automatic logic [N-1:0] exp_grant(input bit avail);
        logic [N-1:0] g = '0;
        int best = -1;
        if (!avail) return g;
        for (int i = 0; i < N; i++) begin
            if (m_valid[i] && m_ready[i]) begin
                if (best < 0 || m_age[i] < m_age[best]) best = i;
            end
        end
        if (best >= 0) g[best] = 1'b1;
        return g;
    endfunction

    function automatic int lowest_free();
        for (int i = 0; i < N; i++) if (!m_valid[i]) return i;
        return -1;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [N-1:0] act,
                         input logic [N-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check before the edge, update the model at it.
    task automatic step(input bit al, input logic [N-1:0] rs, input bit av, input string tag);
        logic [N-1:0] eg;
        int slot;
        @(negedge clk);
        alloc_i = al;
        ready_set_i = rs;
        res_avail_i = av;
        #1;
        eg = exp_grant(av);
        check(grant_o === eg, tag, grant_o, eg);
        check($countones(grant_o) <= 1, "R3", grant_o, eg);
        slot = al ? lowest_free() : -1;
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            if (eg[i]) begin
                m_valid[i] = 1'b0;
                m_ready[i] = 1'b0;
            end else if (m_valid[i] && rs[i]) begin
                m_ready[i] = 1'b1;
            end
        end
        if (slot >= 0) begin
            m_valid[slot] = 1'b1;
            m_ready[slot] = 1'b0;
            m_age[slot]   = m_stamp;
            m_stamp++;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 1'b0;
            m_ready[i] = 1'b0;
            m_age[i]   = 0;
        end
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PER * MAX_CYC);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0A17);
        do_reset();

        // R8: empty after reset, strobes on free slots give no grant.
        step(1'b0, '1, 1'b1, "R8");
        step(1'b0, '0, 1'b1, "R8");

        // R1: fill all slots, then a refused request; R2: busy means no grant.
        for (int k = 0; k < N; k++) step(1'b1, '0, 1'b0, "R1");
        step(1'b1, '0, 1'b0, "R1");
        step(1'b0, '1, 1'b0, "R2");
        // R4/R5: grants come out oldest first, each once.
        for (int k = 0; k < N; k++) step(1'b0, '0, 1'b1, "R4");
        step(1'b0, '0, 1'b1, "R5");

        // R6: ready strobe to free slot 0 is lost.
        step(1'b0, 10'b1, 1'b1, "R6");
        step(1'b1, '0, 1'b1, "R6");
        step(1'b0, '0, 1'b1, "R6");
        step(1'b0, '0, 1'b1, "R6");
        do_reset();

        // R9: holes in slots 1 and 3 refilled with younger entries.
        for (int k = 0; k < 5; k++) step(1'b1, '0, 1'b0, "R9");
        step(1'b0, 10'b0000001010, 1'b0, "R9");
        step(1'b0, '0, 1'b1, "R9");
        step(1'b0, '0, 1'b1, "R9");
        step(1'b1, '0, 1'b0, "R9");
        step(1'b1, '0, 1'b0, "R9");
        step(1'b0, 10'b0000011111, 1'b0, "R9");
        for (int k = 0; k < 6; k++) step(1'b0, '0, 1'b1, "R9");

        // R7/R4: random mix.
        for (int c = 0; c < 3000; c++) begin
            logic [N-1:0] rs;
            rs = '0;
            for (int i = 0; i < N; i++) rs[i] = ($urandom % 4) == 0;
            step(($urandom % 2) == 0, rs, ($urandom % 5) < 3, "R7");
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule